// File: doc/BRIEF.md
# GPIO Port Bank with Pin Interrupts

This block is a bank of eight general-purpose I/O ports, eight pins wide each, controlled through a simple register read/write bus. Each port has an output latch and a direction register. Together they drive the pad outputs and output enables. Reading a port's data register returns the synchronized level seen on its pins.

Ports 0, 1 and 5 also carry per-pin interrupt logic. For each pin there is an enable, an edge-or-level selection, a polarity selection and an optional debounce filter. A write-one-to-clear register releases latched edge events. Ports 0 and 1 share one OR-ed interrupt output. Each pin of port 5 drives an interrupt output of its own. Software sets a pin's trigger, enables it, services the line and writes the clear register. The block does not model pad electronics or the system interrupt controller.

Top module: `gpio_port_irq_ctrl`

## Requirements
- R1: After reset every register is zero: all pins are inputs (`pin_oe` = 0), `pin_out` = 0, and no interrupt output is active.
- R2: A direction bit of 1 drives the matching `pin_oe` bit high, and 0 makes the pin an input. The output latch drives `pin_out`. Both take effect the cycle after the write. A data-register read returns the pin level after a two-flop synchronizer, so a change on `pin_in` becomes readable after the second rising clock edge.
- R3: Address bits [5:3] select the port and bits [2:0] select the register: 0 output latch/pin level, 1 direction, 2 interrupt enable, 3 trigger mode, 4 trigger polarity, 5 clear (write-only, reads 0), 6 debounce enable, 7 interrupt status (read-only). Reads are combinational while `bus_en` is high.
- R4: Only ports 0, 1 and 5 implement codes 2 to 7. On the other ports these codes read 0 and writes to them have no effect.
- R5: With trigger mode 1 (edge), polarity 1 selects rising edges and polarity 0 selects falling edges. A detected edge sets a pending bit, and that bit stays set after the input returns.
- R6: With trigger mode 0 (level), polarity 1 means active-high and polarity 0 means active-low. The interrupt follows the live qualified level and needs no clear.
- R7: Writing the clear register clears the pending bits written as 1 and leaves the bits written as 0 unchanged. A new edge in the same cycle wins over the clear.
- R8: A pending bit can be set only while the pin's enable is 1. Clearing the enable drops the pending bit, and turning the enable back on does not bring back an edge that has already passed.
- R9: Active interrupts of ports 0 and 1 are OR-ed onto `irq_shared`. An active interrupt on port 5 pin i drives `irq_pin[i]` only.
- R10: With debounce enabled, a new level is accepted only after the synchronized input has held it for 4 consecutive clocks. A 3-cycle pulse is ignored. Without debounce, a 1-cycle pulse is caught as an edge.
- R11: The status register reads back each pin's active interrupt: enabled, and either pending (edge mode) or at its active level (level mode).
- R12: An edge interrupt appears after the third rising edge following the input change: two synchronizer edges plus the pending latch. Debounce adds four more edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Port number [5:3] and register code [2:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when idle |
| pin_in | input | 64 | Pin levels, port p at bits [8p+7:8p] |
| pin_out | output | 64 | Output latch values |
| pin_oe | output | 64 | Output enables, 1 = drive |
| irq_shared | output | 1 | OR of active interrupts of ports 0 and 1 |
| irq_pin | output | 8 | One interrupt per pin of port 5 |

## Verification
A corrupted pending bit shows up within one cycle, as a stray or missing `irq_pin` bit or `irq_shared`, and in the status register. A wrong enable or clear shows up as a line that stays asserted after service or fires while disabled. An error in the debounce counter moves the interrupt edge earlier or later by whole cycles, or lets a 3-cycle glitch through, so the bench samples the outputs on exact cycles around each threshold. A wrong synchronizer depth shows up as a data read that changes one edge early or late.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

  typedef enum logic [2:0] {
    RG_DATA = 3'd0,
    RG_DIR  = 3'd1,
    RG_IEN  = 3'd2,
    RG_MODE = 3'd3,
    RG_POL  = 3'd4,
    RG_CLR  = 3'd5,
    RG_DBEN = 3'd6,
    RG_STAT = 3'd7
  } gpio_reg_e;

  localparam int N_IRQ_UNITS  = 3;
  localparam int IRQ_PORT_SH0 = 0;
  localparam int IRQ_PORT_SH1 = 1;
  localparam int IRQ_PORT_IND = 5;

  // interrupt unit index for a port, -1 when the port has none
  function automatic int unit_of_port(int p);
    if (p == IRQ_PORT_SH0) return 0;
    if (p == IRQ_PORT_SH1) return 1;
    if (p == IRQ_PORT_IND) return 2;
    return -1;
  endfunction

  function automatic int port_of_unit(int k);
    if (k == 0) return IRQ_PORT_SH0;
    if (k == 1) return IRQ_PORT_SH1;
    return IRQ_PORT_IND;
  endfunction

  // selected transition between previous and current filtered level
  function automatic logic edge_hit(logic pol, logic prv, logic cur);
    return pol ? (~prv & cur) : (prv & ~cur);
  endfunction

  // level qualifies as active for the chosen polarity
  function automatic logic level_hit(logic pol, logic cur);
    return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W      = 8,
  parameter int STABLE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic          st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= 1'b0;
        cnt <= '0;
      end else if (d[i] == st) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        st  <= d[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign q[i] = st;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_ctl_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  gpio_reg_e        code,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] rd,
  output logic [NPINS-1:0] act,
  output logic [NPINS-1:0] ien_o,
  output logic [NPINS-1:0] pend_o,
  output logic [NPINS-1:0] edge_o,
  output logic [NPINS-1:0] db_o
);
  logic [NPINS-1:0] ien, mode, pol, dben, prev, pend;
  logic [NPINS-1:0] db_lvl, filt, edge_ev, lvl_ev, clr_mask;

  gpio_debounce #(.W(NPINS), .STABLE(DB_CYCLES)) u_db (
    .clk(clk), .rst_n(rst_n), .d(lvl), .q(db_lvl)
  );

  assign filt     = (dben & db_lvl) | (~dben & lvl);
  assign clr_mask = (wr && code == RG_CLR) ? wdata : '0;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      edge_ev[i] = mode[i] & edge_hit(pol[i], prev[i], filt[i]);
      lvl_ev[i]  = ~mode[i] & level_hit(pol[i], filt[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      mode <= '0;
      pol  <= '0;
      dben <= '0;
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= filt;
      pend <= ien & (edge_ev | (pend & ~clr_mask));
      if (wr) begin
        case (code)
          RG_IEN:  ien  <= wdata;
          RG_MODE: mode <= wdata;
          RG_POL:  pol  <= wdata;
          RG_DBEN: dben <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign act = ien & ((mode & pend) | lvl_ev);

  always_comb begin
    case (code)
      RG_IEN:  rd = ien;
      RG_MODE: rd = mode;
      RG_POL:  rd = pol;
      RG_DBEN: rd = dben;
      RG_STAT: rd = act;
      default: rd = '0;
    endcase
  end

  assign ien_o  = ien;
  assign pend_o = pend;
  assign edge_o = edge_ev;
  assign db_o   = db_lvl;
endmodule

// File: rtl/gpio_port_irq_ctrl.sv
module gpio_port_irq_ctrl
  import gpio_ctl_pkg::*;
#(
  parameter int NPORTS    = 8,
  parameter int NPINS     = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_en,
  input  logic                        bus_we,
  input  logic [$clog2(NPORTS)+2:0]   bus_addr,
  input  logic [NPINS-1:0]            bus_wdata,
  output logic [NPINS-1:0]            bus_rdata,
  input  logic [NPORTS*NPINS-1:0]     pin_in,
  output logic [NPORTS*NPINS-1:0]     pin_out,
  output logic [NPORTS*NPINS-1:0]     pin_oe,
  output logic                        irq_shared,
  output logic [NPINS-1:0]            irq_pin
);
  localparam int PW = $clog2(NPORTS);
  localparam int AW = PW + 3;

  gpio_reg_e        code;
  logic [PW-1:0]    port_sel;
  logic             wr_any;
  logic [NPINS-1:0] rd_by_port [NPORTS];

  // per interrupt unit views, named for the checker
  logic [N_IRQ_UNITS-1:0][NPINS-1:0] u_ien, u_pend, u_edge, u_db, u_lvl, u_act;

  assign code     = gpio_reg_e'(bus_addr[2:0]);
  assign port_sel = bus_addr[AW-1:3];
  assign wr_any   = bus_en & bus_we;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [NPINS-1:0] data_q, dir_q, lvl_q, irq_rd;
    logic             wr_hit;

    assign wr_hit = wr_any && (port_sel == PW'(p));

    gpio_sync2 #(.W(NPINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in[p*NPINS +: NPINS]), .q(lvl_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        dir_q  <= '0;
      end else if (wr_hit) begin
        if (code == RG_DATA) data_q <= bus_wdata;
        if (code == RG_DIR)  dir_q  <= bus_wdata;
      end
    end

    assign pin_out[p*NPINS +: NPINS] = data_q;
    assign pin_oe[p*NPINS +: NPINS]  = dir_q;

    if (unit_of_port(p) >= 0) begin : g_irq
      localparam int K = unit_of_port(p);
      gpio_irq_port #(.NPINS(NPINS), .DB_CYCLES(DB_CYCLES)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr(wr_hit), .code(code),
        .wdata(bus_wdata), .lvl(lvl_q), .rd(irq_rd), .act(u_act[K]),
        .ien_o(u_ien[K]), .pend_o(u_pend[K]), .edge_o(u_edge[K]),
        .db_o(u_db[K])
      );
      assign u_lvl[K] = lvl_q;
    end else begin : g_plain
      assign irq_rd = '0;
    end

    assign rd_by_port[p] = (code == RG_DATA) ? lvl_q :
                           (code == RG_DIR)  ? dir_q : irq_rd;
  end

  assign bus_rdata  = bus_en ? rd_by_port[port_sel] : '0;
  assign irq_shared = (|u_act[0]) | (|u_act[1]);
  assign irq_pin    = u_act[2];
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_ctl_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int NPINS  = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              bus_en,
  input logic                              bus_we,
  input logic [$clog2(NPORTS)+2:0]         bus_addr,
  input logic [NPINS-1:0]                  bus_wdata,
  input logic [NPORTS*NPINS-1:0]           pin_oe,
  input logic [NPORTS*NPINS-1:0]           pin_out,
  input logic                              irq_shared,
  input logic [NPINS-1:0]                  irq_pin,
  input logic [N_IRQ_UNITS-1:0][NPINS-1:0] u_ien,
  input logic [N_IRQ_UNITS-1:0][NPINS-1:0] u_pend,
  input logic [N_IRQ_UNITS-1:0][NPINS-1:0] u_edge,
  input logic [N_IRQ_UNITS-1:0][NPINS-1:0] u_db,
  input logic [N_IRQ_UNITS-1:0][NPINS-1:0] u_lvl
);
  localparam int PW = $clog2(NPORTS);

  logic [NPORTS-1:0][NPINS-1:0] oe2, out2;
  logic [PW-1:0] port_sel;
  logic          wr_dir, wr_dat;

  assign oe2      = pin_oe;
  assign out2     = pin_out;
  assign port_sel = bus_addr[PW+2:3];
  assign wr_dir   = bus_en && bus_we && bus_addr[2:0] == RG_DIR;
  assign wr_dat   = bus_en && bus_we && bus_addr[2:0] == RG_DATA;

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> oe2[$past(port_sel)] == $past(bus_wdata)); // R2
  AST_OUT_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> out2[$past(port_sel)] == $past(bus_wdata)); // R2
  AST_SHARED_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> ((|u_ien[0]) || (|u_ien[1]))); // R9
  AST_PIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ~u_ien[2]) == '0); // R9

  for (genvar k = 0; k < N_IRQ_UNITS; k++) begin : g_unit
    logic clr_k;
    assign clr_k = bus_en && bus_we && bus_addr[2:0] == RG_CLR &&
                   port_sel == PW'(port_of_unit(k));

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (u_pend[k] & ~$past(u_pend[k]) & ~$past(u_ien[k])) == '0); // R8
    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (u_pend[k] & ~$past(u_pend[k]) & ~$past(u_edge[k])) == '0); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_k |=> (u_pend[k] & $past(bus_wdata) & ~$past(u_edge[k])) == '0); // R7
    AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((u_db[k] ^ $past(u_db[k])) & (u_db[k] ^ $past(u_lvl[k]))) == '0); // R10
  end
endmodule

bind gpio_port_irq_ctrl gpio_irq_checker #(.NPORTS(NPORTS), .NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
  .pin_out(pin_out), .irq_shared(irq_shared), .irq_pin(irq_pin),
  .u_ien(u_ien), .u_pend(u_pend), .u_edge(u_edge), .u_db(u_db),
  .u_lvl(u_lvl)
);

// File: tb/sim_gpio_port_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq_shared;
  logic [7:0]  irq_pin;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_shared(irq_shared), .irq_pin(irq_pin)
  );

  // entry: {write, addr, wdata, expected read}; addr = port*8 + code
  localparam int NV = 18;
  localparam logic [22:0] TBL [NV] = '{
    {1'b1, 6'd17, 8'h5A, 8'h00}, {1'b0, 6'd17, 8'h00, 8'h5A},
    {1'b1, 6'd24, 8'h3C, 8'h00}, {1'b0, 6'd25, 8'h00, 8'h00},
    {1'b1, 6'd26, 8'hFF, 8'h00}, {1'b0, 6'd26, 8'h00, 8'h00},
    {1'b1, 6'd2,  8'h0F, 8'h00}, {1'b0, 6'd2,  8'h00, 8'h0F},
    {1'b1, 6'd43, 8'hAA, 8'h00}, {1'b0, 6'd43, 8'h00, 8'hAA},
    {1'b1, 6'd45, 8'hFF, 8'h00}, {1'b0, 6'd45, 8'h00, 8'h00},
    {1'b1, 6'd12, 8'h81, 8'h00}, {1'b0, 6'd12, 8'h00, 8'h81},
    {1'b1, 6'd54, 8'hFF, 8'h00}, {1'b0, 6'd54, 8'h00, 8'h00},
    {1'b1, 6'd6,  8'h33, 8'h00}, {1'b0, 6'd6,  8'h00, 8'h33}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] e);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, {56'd0, bus_rdata}, {56'd0, e});
    bus_en = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 64'h0);
    chk("R1 pin_out", pin_out, 64'h0);
    chk("R1 irq lines", {55'd0, irq_shared, irq_pin}, 64'h0);
    rd_chk("R1 port5 mode", 6'd43, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][22]) wr(TBL[i][21:16], TBL[i][15:8]);
      else rd_chk("R3 or R4 table", TBL[i][21:16], TBL[i][7:0]);
    end
    wr(6'd2, 8'h00);
    wr(6'd6, 8'h00);

    // R2 outputs and synchronized read
    chk("R2 pin_oe", pin_oe, 64'h0000_0000_005A_0000);
    chk("R2 pin_out", pin_out, 64'h0000_0000_3C00_0000);
    pin_in[39:32] = 8'h96;
    tick(1);
    rd_chk("R2 read after one edge", 6'd32, 8'h00);
    tick(1);
    rd_chk("R2 read after two edges", 6'd32, 8'h96);
    rd_chk("R4 port3 status", 6'd31, 8'h00);

    // R5/R12 rising edge on port 5 pin 3
    wr(6'd43, 8'hFF); wr(6'd44, 8'hFF); wr(6'd46, 8'h00);
    wr(6'd42, 8'hFF); wr(6'd45, 8'hFF);
    pin_in[43] = 1'b1;
    tick(2);
    chk("R12 edge not yet", {56'd0, irq_pin}, 64'h00);
    tick(1);
    chk("R12 edge latency", {56'd0, irq_pin}, 64'h08);
    pin_in[43] = 1'b0;
    tick(4);
    chk("R5 pending held", {56'd0, irq_pin}, 64'h08);
    chk("R9 port5 not shared", {63'd0, irq_shared}, 64'h0);
    rd_chk("R11 status port5", 6'd47, 8'h08);
    wr(6'd45, 8'h01);
    chk("R7 zero bit kept", {56'd0, irq_pin}, 64'h08);
    wr(6'd45, 8'h08);
    chk("R7 cleared", {56'd0, irq_pin}, 64'h00);

    // R10 one-cycle pulse without debounce
    pin_in[41] = 1'b1;
    tick(1);
    pin_in[41] = 1'b0;
    tick(2);
    chk("R10 short pulse no debounce", {56'd0, irq_pin}, 64'h02);
    wr(6'd45, 8'hFF);

    // R8 enable gating
    wr(6'd42, 8'h00);
    pin_in[45] = 1'b1;
    tick(4);
    chk("R8 disabled edge", {56'd0, irq_pin}, 64'h00);
    wr(6'd42, 8'hFF);
    chk("R8 no retro pending", {56'd0, irq_pin}, 64'h00);
    pin_in[45] = 1'b0;
    tick(3);
    pin_in[46] = 1'b1;
    tick(3);
    chk("R8 enabled edge", {56'd0, irq_pin}, 64'h40);
    wr(6'd42, 8'hBF);
    chk("R8 masked", {56'd0, irq_pin}, 64'h00);
    wr(6'd42, 8'hFF);
    chk("R8 pending dropped", {56'd0, irq_pin}, 64'h00);
    pin_in[46] = 1'b0;
    tick(3);

    // R10 debounce on port 5 pin 2
    wr(6'd46, 8'h04);
    pin_in[42] = 1'b1;
    tick(3);
    pin_in[42] = 1'b0;
    tick(8);
    chk("R10 3-cycle glitch ignored", {56'd0, irq_pin}, 64'h00);
    pin_in[42] = 1'b1;
    tick(4);
    pin_in[42] = 1'b0;
    tick(2);
    chk("R10 before accept", {56'd0, irq_pin}, 64'h00);
    tick(1);
    chk("R12 debounced edge", {56'd0, irq_pin}, 64'h04);
    tick(6);
    wr(6'd45, 8'hFF);
    wr(6'd42, 8'h00);

    // R5/R9 falling edge on port 0 pin 1
    wr(6'd3, 8'hFF); wr(6'd4, 8'h00); wr(6'd6, 8'h00);
    pin_in[1] = 1'b1;
    tick(3);
    wr(6'd2, 8'h02); wr(6'd5, 8'hFF);
    chk("R9 shared idle", {63'd0, irq_shared}, 64'h0);
    pin_in[1] = 1'b0;
    tick(2);
    chk("R5 falling not yet", {63'd0, irq_shared}, 64'h0);
    tick(1);
    chk("R5 falling edge shared", {63'd0, irq_shared}, 64'h1);
    chk("R9 irq_pin quiet", {56'd0, irq_pin}, 64'h0);
    wr(6'd5, 8'h02);
    chk("R7 shared cleared", {63'd0, irq_shared}, 64'h0);
    wr(6'd2, 8'h00);

    // R6 level on port 1 pin 7
    wr(6'd11, 8'h00); wr(6'd12, 8'h80); wr(6'd10, 8'h80);
    pin_in[15] = 1'b1;
    tick(2);
    chk("R6 high level", {63'd0, irq_shared}, 64'h1);
    rd_chk("R11 status port1", 6'd15, 8'h80);
    pin_in[15] = 1'b0;
    tick(1);
    chk("R6 still high in sync", {63'd0, irq_shared}, 64'h1);
    tick(1);
    chk("R6 level released", {63'd0, irq_shared}, 64'h0);
    wr(6'd12, 8'h00);
    chk("R6 low level", {63'd0, irq_shared}, 64'h1);
    wr(6'd10, 8'h00);
    chk("R6 disabled", {63'd0, irq_shared}, 64'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule